// File: doc/BRIEF.md
# Stopwatch with Best-Time Memory

This block is a small stopwatch built as a control state machine and a datapath. A decimal up-counter measures the current run. It advances only on a one-cycle time-base pulse, and only while a run is in progress. A second register keeps the lowest time recorded so far. That register starts at the all-nines value, so the first completed run always replaces it.

When a run is stopped, a digit-wise magnitude comparator decides whether the frozen time beats the stored best, and the controller loads the register only in that case. The 16-bit output feeds an external digit decoder. It is a registered display value that shows one of two things: the running or frozen count, or the stored best time in a separate show mode. A synchronous clear button returns the watch to idle and restores the all-nines best time.

Top module: `best_time_watch`

## Requirements
- R1: After the asynchronous reset `rst_n`, the display reads 0 and the stored best time is all nines (0x9999 in packed BCD, one digit per nibble, most significant digit in the top nibble).
- R2: A `start_i` pulse from idle, halted or show mode clears the counter to 0000 and begins a run.
- R3: The counter advances by one only on a `tick_i` pulse while a run is in progress. Ticks in idle, halted or show mode leave the counter and the display unchanged.
- R4: Each digit counts 0 to 9 and then wraps to 0 with a carry into the next digit. The value 9999 wraps to 0000.
- R5: A `stop_i` pulse during a run freezes the counter. The display keeps showing the frozen count, and later ticks do not move it.
- R6: After a stop, the best time takes the frozen count only if the count is strictly less than the best time. Otherwise the best time is unchanged.
- R7: A `css_i` pulse in idle or halted mode enters show mode, where the display presents the stored best time.
- R8: A `clr_i` pulse in any state returns the watch to idle, clears the counter and the display to 0000, and presets the best time to 9999.
- R9: When `start_i` and `css_i` arrive in the same cycle, the start wins and a run begins. `clr_i` outranks both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-run button pulse |
| stop_i | input | 1 | Stop-run button pulse |
| css_i | input | 1 | Show-best button pulse |
| clr_i | input | 1 | Synchronous clear button pulse |
| tick_i | input | 1 | One-cycle time-base pulse |
| disp_o | output | 16 | Registered display value, packed BCD |

## Verification
The assertions assume two things. First, the button inputs are synchronous single-cycle pulses. Second, the counter and the best register only ever hold valid BCD digits, which holds because both start from reset values and change only through the digit logic. The digit-wise comparator is checked against plain binary ordering, and that check is valid only under this condition. The stimulus drives every input on the falling edge as a one-cycle pulse. It keeps `tick_i` low in the cycle that carries a stop, and it sweeps the counter across its full cycle, including the wrap, so that every digit value and every carry is exercised.

// File: rtl/bwatch_pkg.sv
package bwatch_pkg;

   localparam int unsigned BCD_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ZERO = 3'd1,
      ST_RUN  = 3'd2,
      ST_CMP  = 3'd3,
      ST_SAVE = 3'd4,
      ST_HALT = 3'd5,
      ST_SHOW = 3'd6
   } wst_e;

   typedef struct packed {
      logic cnt_clear;
      logic cnt_enable;
      logic best_preset;
      logic best_load;
      logic disp_update;
      logic disp_best;
   } wctl_t;

endpackage

// File: rtl/bwatch_bcd_counter.sv
module bwatch_bcd_counter
   import bwatch_pkg::*;
#(
   parameter int unsigned DIGITS = 4,
   localparam int unsigned TW = DIGITS * BCD_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   output logic [TW-1:0] value
);

   logic [DIGITS:0] carry;

   assign carry[0] = step;

   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      logic [BCD_W-1:0] d_q;
      logic             at_nine;

      assign at_nine      = (d_q == BCD_W'(9));
      assign carry[g+1]   = carry[g] & at_nine;
      assign value[g*BCD_W +: BCD_W] = d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
         end else if (clear) begin
            d_q <= '0;
         end else if (carry[g]) begin
            d_q <= at_nine ? '0 : d_q + BCD_W'(1);
         end
      end

      AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
         d_q <= BCD_W'(9)); // R4
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !step) |=> $stable(value)); // R3
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (value == '0)); // R2

endmodule

// File: rtl/bwatch_bcd_less.sv
module bwatch_bcd_less
   import bwatch_pkg::*;
#(
   parameter int unsigned DIGITS = 4,
   localparam int unsigned TW = DIGITS * BCD_W
) (
   input  logic [TW-1:0] lhs,
   input  logic [TW-1:0] rhs,
   output logic          lt
);

   logic [DIGITS:0] lt_c;
   logic [DIGITS:0] eq_c;

   assign lt_c[DIGITS] = 1'b0;
   assign eq_c[DIGITS] = 1'b1;

   for (genvar g = DIGITS - 1; g >= 0; g--) begin : g_cmp
      logic [BCD_W-1:0] a_d;
      logic [BCD_W-1:0] b_d;
      assign a_d     = lhs[g*BCD_W +: BCD_W];
      assign b_d     = rhs[g*BCD_W +: BCD_W];
      assign lt_c[g] = lt_c[g+1] | (eq_c[g+1] & (a_d < b_d));
      assign eq_c[g] = eq_c[g+1] & (a_d == b_d);
   end

   assign lt = lt_c[0];

endmodule

// File: rtl/bwatch_ctrl.sv
module bwatch_ctrl
   import bwatch_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  stop,
   input  logic  css,
   input  logic  clr,
   input  logic  time_lt,
   output wctl_t ctl
);

   wst_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (clr) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ZERO;
                     else if (css) st_d = ST_SHOW;
            ST_ZERO: st_d = ST_RUN;
            ST_RUN:  if (stop) st_d = ST_CMP;
            ST_CMP:  st_d = time_lt ? ST_SAVE : ST_HALT;
            ST_SAVE: st_d = ST_HALT;
            ST_HALT: if (start) st_d = ST_ZERO;
                     else if (css) st_d = ST_SHOW;
            ST_SHOW: if (start) st_d = ST_ZERO;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      ctl = '0;
      unique case (st_q)
         ST_IDLE: begin
            ctl.cnt_clear   = 1'b1;
            ctl.best_preset = 1'b1;
            ctl.disp_update = 1'b1;
         end
         ST_ZERO: begin
            ctl.cnt_clear   = 1'b1;
            ctl.disp_update = 1'b1;
         end
         ST_RUN: begin
            ctl.cnt_enable  = 1'b1;
            ctl.disp_update = 1'b1;
         end
         ST_CMP:  ctl = '0;
         ST_SAVE: ctl.best_load = 1'b1;
         ST_HALT: ctl.disp_update = 1'b1;
         ST_SHOW: begin
            ctl.disp_update = 1'b1;
            ctl.disp_best   = 1'b1;
         end
         default: ctl = '0;
      endcase
   end

   AST_CTL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl.cnt_enable, ctl.best_load, ctl.best_preset})); // R5
   AST_STOP_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && stop && !clr) |=> (st_q == ST_CMP)); // R5
   AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_IDLE || st_q == ST_HALT || st_q == ST_SHOW) && start && !clr)
      |=> (st_q == ST_ZERO)); // R9
   AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (st_q == ST_IDLE)); // R8

endmodule

// File: rtl/best_time_watch.sv
module best_time_watch
   import bwatch_pkg::*;
#(
   parameter int unsigned DIGITS = 4,
   localparam int unsigned TW = DIGITS * BCD_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic          css_i,
   input  logic          clr_i,
   input  logic          tick_i,
   output logic [TW-1:0] disp_o
);

   if (DIGITS < 1 || DIGITS > 8) begin : g_bad_digits
      $error("best_time_watch: DIGITS must be within 1..8");
   end

   wctl_t         ctl;
   logic [TW-1:0] cnt;
   logic [TW-1:0] best_q;
   logic [TW-1:0] all_nine;
   logic [TW-1:0] disp_q;
   logic          cnt_lt;

   for (genvar g = 0; g < DIGITS; g++) begin : g_nine
      assign all_nine[g*BCD_W +: BCD_W] = BCD_W'(9);
   end

   bwatch_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .stop    (stop_i),
      .css     (css_i),
      .clr     (clr_i),
      .time_lt (cnt_lt),
      .ctl     (ctl)
   );

   bwatch_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ctl.cnt_clear),
      .step  (ctl.cnt_enable & tick_i),
      .value (cnt)
   );

   bwatch_bcd_less #(.DIGITS(DIGITS)) u_cmp (
      .lhs (cnt),
      .rhs (best_q),
      .lt  (cnt_lt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_q <= all_nine;
      end else if (ctl.best_preset) begin
         best_q <= all_nine;
      end else if (ctl.best_load) begin
         best_q <= cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_q <= '0;
      end else if (ctl.disp_update) begin
         disp_q <= ctl.disp_best ? best_q : cnt;
      end
   end

   assign disp_o = disp_q;

   AST_BEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.best_preset && !ctl.best_load) |=> $stable(best_q)); // R6
   AST_BEST_IMPROVES: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.best_load |=> (best_q < $past(best_q))); // R6
   AST_LT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_lt == (cnt < best_q)); // R6
   AST_BEST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.best_preset |=> (best_q == all_nine)); // R8
   AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.disp_update |=> $stable(disp_q)); // R5
   AST_SHOW_BEST: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.disp_update && ctl.disp_best) |=> (disp_q == $past(best_q))); // R7

endmodule

// File: tb/best_time_watch_bench.sv
module best_time_watch_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        stop_i = 1'b0;
   logic        css_i = 1'b0;
   logic        clr_i = 1'b0;
   logic        tick_i = 1'b0;
   logic [15:0] disp_o;

   int checks = 0;
   int errors = 0;
   int best_m = 9999;

   always #2 clk = ~clk;

   best_time_watch u_best_time_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .stop_i  (stop_i),
      .css_i   (css_i),
      .clr_i   (clr_i),
      .tick_i  (tick_i),
      .disp_o  (disp_o)
   );

   function automatic logic [15:0] to_bcd(int v);
      int w = v % 10000;
      return {4'(w / 1000), 4'((w / 100) % 10), 4'((w / 10) % 10), 4'(w % 10)};
   endfunction

   task automatic check(string req, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: display %h, expected %h", req, got, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start(); start_i = 1'b1; @(negedge clk); start_i = 1'b0; endtask
   task automatic pulse_stop();  stop_i  = 1'b1; @(negedge clk); stop_i  = 1'b0; endtask
   task automatic pulse_css();   css_i   = 1'b1; @(negedge clk); css_i   = 1'b0; endtask
   task automatic pulse_clr();   clr_i   = 1'b1; @(negedge clk); clr_i   = 1'b0; endtask

   task automatic ticks(int n);
      tick_i = 1'b1;
      wait_cyc(n);
      tick_i = 1'b0;
   endtask

   // one complete run of n ticks, then stop and settle; updates best model
   task automatic run_lap(int n, string req);
      pulse_start();
      wait_cyc(1);
      ticks(n);
      pulse_stop();
      wait_cyc(4);
      check(req, disp_o, to_bcd(n));
      if ((n % 10000) < best_m) best_m = n % 10000;
   endtask

   task automatic show_best(string req);
      pulse_css();
      wait_cyc(2);
      check(req, disp_o, to_bcd(best_m));
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1 reset display", disp_o, 16'h0000);
      rst_n = 1'b1;
      wait_cyc(2);
      check("R1 idle display", disp_o, 16'h0000);

      // R3: ticks while idle do nothing
      ticks(5);
      wait_cyc(2);
      check("R3 idle ticks ignored", disp_o, 16'h0000);

      // R1/R7: best time preset visible in show mode
      show_best("R1 R7 preset best shown");
      ticks(3);
      wait_cyc(1);
      check("R3 show ticks ignored", disp_o, to_bcd(best_m));

      // R2/R3/R4: full sweep of the counter including the wrap
      pulse_start();
      wait_cyc(1);
      tick_i = 1'b1;
      for (int k = 1; k <= 10001; k++) begin
         @(negedge clk);
         check("R4 sweep", disp_o, to_bcd(k - 1));
      end
      tick_i = 1'b0;
      pulse_stop();
      wait_cyc(4);
      check("R5 frozen after wrap", disp_o, to_bcd(10001));
      if (1 < best_m) best_m = 1;
      ticks(6);
      wait_cyc(2);
      check("R5 halted ticks ignored", disp_o, to_bcd(10001));
      show_best("R6 wrapped time saved");

      // R6: slower lap keeps the best
      run_lap(50, "R2 lap of 50");
      show_best("R6 slower lap ignored");

      // R8: clear presets the best time
      pulse_clr();
      wait_cyc(2);
      check("R8 clear display", disp_o, 16'h0000);
      best_m = 9999;
      show_best("R8 best preset after clear");

      run_lap(1234, "R3 lap of 1234");
      show_best("R6 first lap saved");
      run_lap(1234, "R3 equal lap");
      show_best("R6 equal lap keeps best");
      run_lap(2000, "R3 lap of 2000");
      show_best("R6 slower lap keeps best");
      run_lap(999, "R4 lap of 999");
      show_best("R6 faster lap saved");

      // R9: start and css together start a run
      start_i = 1'b1;
      css_i   = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      css_i   = 1'b0;
      wait_cyc(1);
      ticks(3);
      pulse_stop();
      wait_cyc(4);
      check("R9 start wins over css", disp_o, to_bcd(3));
      if (3 < best_m) best_m = 3;
      show_best("R6 three saved");

      // R8: clear during a run
      pulse_start();
      wait_cyc(1);
      ticks(7);
      pulse_clr();
      wait_cyc(2);
      check("R8 clear during run", disp_o, 16'h0000);
      best_m = 9999;
      ticks(4);
      wait_cyc(2);
      check("R3 ticks after clear ignored", disp_o, 16'h0000);
      show_best("R8 best preset after run clear");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule